// File: doc/BRIEF.md
# Activity and Inactivity Detector

This block watches three-axis acceleration samples and reports two kinds of motion event. An activity event fires when any enabled axis moves past an 8-bit activity threshold. An inactivity event fires when every enabled axis has stayed under an 8-bit inactivity threshold for a programmed number of seconds. Each function can work in one of two ways. In dc-coupled operation it compares the sample magnitude itself. In ac-coupled operation it compares the magnitude of the difference between the sample and a captured reference sample.

A link option puts the two functions in series. The block first looks for inactivity. Once it sees inactivity, it looks only for activity, and once it sees activity it returns to looking for inactivity. When the auto-sleep option is also set, inactivity raises a sleep request and activity drops it again. Samples arrive on a valid/ready stream. The block never applies back-pressure: `smp_ready` stays high, and every cycle with `smp_valid` high delivers one sample. Seconds come from a one-cycle tick input.

Top module: `act_inact_det`

## Requirements
- R1: `smp_ready` is held high, so a sample is taken on every rising clock edge at which `smp_valid` is high. Axis X sits in `smp_data[SW-1:0]`, Y in the next SW bits and Z in the top SW bits, each as a two's complement value. `act_pulse` and `inact_pulse` are single-cycle pulses. They are high during the cycle after the edge that took the sample that caused them.
- R2: With dc coupling, a sample gives `act_pulse` when at least one enabled axis has an absolute value strictly greater than `act_thr`. A value equal to the threshold does not count.
- R3: On each activity event, `act_src` takes the set of enabled axes that exceeded the threshold: bit 2 is X, bit 1 is Y and bit 0 is Z. It holds that value until the next activity event.
- R4: With ac coupling for activity, the first sample taken after activity detection is armed becomes the reference and cannot fire. Later samples fire when any enabled axis differs from the reference by more than `act_thr`. After each activity event, the next sample becomes the new reference.
- R5: The bits of `det_ctl` are assigned as follows. Bit 7 is the activity coupling bit (1 = ac), and bits 6, 5 and 4 enable X, Y and Z for activity. Bit 3 is the inactivity coupling bit, and bits 2, 1 and 0 enable X, Y and Z for inactivity. A disabled axis is ignored. A function whose three enable bits are all clear never fires.
- R6: With dc coupling, a sample is quiet when every enabled axis has an absolute value strictly less than `inact_thr`. A sample that is not quiet restarts the inactivity function. Once inactivity has fired, it fires no more until a sample that is not quiet arrives.
- R7: A quiet sample starts the seconds count from zero, and a quiet sample fires inactivity once at least `inact_time` ticks of `sec_tick` have arrived since the first quiet sample of the run. With `inact_time` = 0, the first quiet sample fires. Ticks that arrive before a quiet run starts are not counted. Firing happens only when a sample arrives.
- R8: With ac coupling for inactivity, quietness is measured against a reference. The first sample after arming becomes the reference, and every sample that is not quiet replaces it.
- R9: When `link_en` is set and both functions have at least one enabled axis, only inactivity is watched at first. After an inactivity event only activity is watched, and after an activity event only inactivity is watched again. Clearing the link returns the block to watching for inactivity first.
- R10: When `link_en` is clear, the two functions run at the same time and do not affect each other.
- R11: `sleep_req` rises with an inactivity pulse when both `link_en` and `autosleep_en` are set. It falls with an activity pulse, or in the cycle after either of those two options is cleared. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | Sample stream ready, always high |
| smp_data | input | 3*SW | Packed X, Y, Z samples, X lowest |
| sec_tick | input | 1 | One-cycle pulse per second |
| act_thr | input | TW | Activity threshold |
| inact_thr | input | TW | Inactivity threshold |
| inact_time | input | TIME_W | Inactivity time in seconds |
| det_ctl | input | 8 | Coupling and axis enable bits |
| link_en | input | 1 | Put the two functions in series |
| autosleep_en | input | 1 | Request sleep on linked inactivity |
| act_pulse | output | 1 | Activity event pulse |
| inact_pulse | output | 1 | Inactivity event pulse |
| act_src | output | 3 | Axes involved in the last activity event, X at bit 2 |
| sleep_req | output | 1 | Sleep request level |

## Verification
The assertions allow the configuration inputs to change between any two cycles, so they refer only to the configuration of the cycle before a pulse. They also rely on every event pulse being traceable to a sample accepted one edge earlier. The stimulus changes configuration only while `smp_valid` is low, and it never raises `sec_tick` in the same cycle as a sample. This keeps the order of ticks and samples unambiguous for the inactivity count. All sample values stay inside the SW-bit signed range, so the difference between a sample and a reference always fits in one extra bit.

// File: rtl/aid_pkg.sv
package aid_pkg;
  localparam int AXES         = 3;
  localparam int CTL_W        = 8;
  localparam int ACT_AC_BIT   = 7;
  localparam int ACT_EN_HI    = 6;
  localparam int INACT_AC_BIT = 3;
  localparam int INACT_EN_HI  = 2;

  typedef enum logic {
    PH_HUNT_INACT = 1'b0,
    PH_HUNT_ACT   = 1'b1
  } link_phase_e;

  // Gather the per-axis enable bits of one function; axis 0 (X) is the
  // highest bit of the field.
  function automatic logic [AXES-1:0] axis_enables(input logic [CTL_W-1:0] ctl,
                                                   input int hi);
    logic [AXES-1:0] en;
    for (int i = 0; i < AXES; i++) en[i] = ctl[hi-i];
    return en;
  endfunction
endpackage

// File: rtl/aid_axis_cmp.sv
// Magnitude of one axis sample, either raw or relative to a reference.
module aid_axis_cmp #(
  parameter int SW = 10
) (
  input  logic [SW-1:0] smp,
  input  logic [SW-1:0] refv,
  input  logic          ac,
  output logic [SW:0]   mag
);
  logic [SW:0] a_ext, b_ext, diff;

  always_comb begin
    a_ext = {smp[SW-1], smp};
    b_ext = ac ? {refv[SW-1], refv} : '0;
    diff  = a_ext - b_ext;
    mag   = diff[SW] ? (~diff + (SW+1)'(1)) : diff;
  end
endmodule

// File: rtl/aid_act_unit.sv
module aid_act_unit import aid_pkg::*; #(
  parameter int SW = 10,
  parameter int TW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               armed,
  input  logic               valid,
  input  logic [AXES*SW-1:0] data,
  input  logic               ac,
  input  logic [AXES-1:0]    en,
  input  logic [TW-1:0]      thr,
  output logic               fire,
  output logic [AXES-1:0]    hits
);
  localparam int MW = SW + 1;

  logic [AXES*SW-1:0] ref_q;
  logic               ref_ok;
  logic [AXES-1:0]    above;
  logic [MW-1:0]      thr_ext;

  assign thr_ext = {{(MW-TW){1'b0}}, thr};

  for (genvar g = 0; g < AXES; g++) begin : g_axis
    logic [MW-1:0] mag;
    aid_axis_cmp #(.SW(SW)) u_cmp (
      .smp  (data[g*SW +: SW]),
      .refv (ref_q[g*SW +: SW]),
      .ac   (ac),
      .mag  (mag)
    );
    assign above[g] = mag > thr_ext;
  end

  assign hits = above & en;
  assign fire = armed && valid && (!ac || ref_ok) && (|hits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q  <= '0;
      ref_ok <= 1'b0;
    end else if (!armed) begin
      ref_ok <= 1'b0;
    end else if (valid) begin
      if (ac && !ref_ok) begin
        ref_q  <= data;
        ref_ok <= 1'b1;
      end else if (fire) begin
        ref_ok <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/aid_inact_unit.sv
module aid_inact_unit import aid_pkg::*; #(
  parameter int SW     = 10,
  parameter int TW     = 8,
  parameter int TIME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               armed,
  input  logic               valid,
  input  logic               tick,
  input  logic [AXES*SW-1:0] data,
  input  logic               ac,
  input  logic [AXES-1:0]    en,
  input  logic [TW-1:0]      thr,
  input  logic [TIME_W-1:0]  limit,
  output logic               fire
);
  localparam int MW = SW + 1;

  logic [AXES*SW-1:0] ref_q;
  logic               ref_ok;
  logic               run_q;
  logic               done_q;
  logic [TIME_W-1:0]  cnt_q;
  logic [AXES-1:0]    calm;
  logic [MW-1:0]      thr_ext;
  logic               quiet, loud;

  assign thr_ext = {{(MW-TW){1'b0}}, thr};

  for (genvar g = 0; g < AXES; g++) begin : g_axis
    logic [MW-1:0] mag;
    aid_axis_cmp #(.SW(SW)) u_cmp (
      .smp  (data[g*SW +: SW]),
      .refv (ref_q[g*SW +: SW]),
      .ac   (ac),
      .mag  (mag)
    );
    assign calm[g] = !en[g] || (mag < thr_ext);
  end

  assign quiet = valid && (!ac || ref_ok) && (&calm);
  assign loud  = valid && !quiet;
  assign fire  = armed && quiet && !done_q && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q  <= '0;
      ref_ok <= 1'b0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!armed) begin
      ref_ok <= 1'b0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (loud) begin
        run_q  <= 1'b0;
        done_q <= 1'b0;
        cnt_q  <= '0;
        if (ac) begin
          ref_q  <= data;
          ref_ok <= 1'b1;
        end
      end else if (quiet) begin
        run_q <= 1'b1;
        if (fire) done_q <= 1'b1;
      end
      if (tick && run_q && !loud && (cnt_q != '1)) cnt_q <= cnt_q + TIME_W'(1);
    end
  end
endmodule

// File: rtl/aid_link_ctl.sv
module aid_link_ctl import aid_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic link_en,
  input  logic sleep_en,
  input  logic act_any,
  input  logic inact_any,
  input  logic act_fire,
  input  logic inact_fire,
  output logic act_arm,
  output logic inact_arm,
  output logic sleep_req
);
  link_phase_e phase_q;
  logic        chained;

  assign chained   = link_en && act_any && inact_any;
  assign act_arm   = act_any   && (!chained || (phase_q == PH_HUNT_ACT));
  assign inact_arm = inact_any && (!chained || (phase_q == PH_HUNT_INACT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_HUNT_INACT;
      sleep_req <= 1'b0;
    end else begin
      if (!chained)        phase_q <= PH_HUNT_INACT;
      else if (inact_fire) phase_q <= PH_HUNT_ACT;
      else if (act_fire)   phase_q <= PH_HUNT_INACT;

      if (!(link_en && sleep_en)) sleep_req <= 1'b0;
      else if (inact_fire)        sleep_req <= 1'b1;
      else if (act_fire)          sleep_req <= 1'b0;
    end
  end
endmodule

// File: rtl/act_inact_det.sv
module act_inact_det import aid_pkg::*; #(
  parameter int SW     = 10,
  parameter int TW     = 8,
  parameter int TIME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  output logic               smp_ready,
  input  logic [AXES*SW-1:0] smp_data,
  input  logic               sec_tick,
  input  logic [TW-1:0]      act_thr,
  input  logic [TW-1:0]      inact_thr,
  input  logic [TIME_W-1:0]  inact_time,
  input  logic [CTL_W-1:0]   det_ctl,
  input  logic               link_en,
  input  logic               autosleep_en,
  output logic               act_pulse,
  output logic               inact_pulse,
  output logic [AXES-1:0]    act_src,
  output logic               sleep_req
);
  logic [AXES-1:0] act_en, inact_en, act_hits, hits_map;
  logic            act_arm, inact_arm, act_fire, inact_fire;

  assign smp_ready = 1'b1;
  assign act_en    = axis_enables(det_ctl, ACT_EN_HI);
  assign inact_en  = axis_enables(det_ctl, INACT_EN_HI);

  aid_link_ctl u_link (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_en    (link_en),
    .sleep_en   (autosleep_en),
    .act_any    (|act_en),
    .inact_any  (|inact_en),
    .act_fire   (act_fire),
    .inact_fire (inact_fire),
    .act_arm    (act_arm),
    .inact_arm  (inact_arm),
    .sleep_req  (sleep_req)
  );

  aid_act_unit #(.SW(SW), .TW(TW)) u_act (
    .clk   (clk),
    .rst_n (rst_n),
    .armed (act_arm),
    .valid (smp_valid),
    .data  (smp_data),
    .ac    (det_ctl[ACT_AC_BIT]),
    .en    (act_en),
    .thr   (act_thr),
    .fire  (act_fire),
    .hits  (act_hits)
  );

  aid_inact_unit #(.SW(SW), .TW(TW), .TIME_W(TIME_W)) u_inact (
    .clk   (clk),
    .rst_n (rst_n),
    .armed (inact_arm),
    .valid (smp_valid),
    .tick  (sec_tick),
    .data  (smp_data),
    .ac    (det_ctl[INACT_AC_BIT]),
    .en    (inact_en),
    .thr   (inact_thr),
    .limit (inact_time),
    .fire  (inact_fire)
  );

  always_comb begin
    for (int i = 0; i < AXES; i++) hits_map[AXES-1-i] = act_hits[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_pulse   <= 1'b0;
      inact_pulse <= 1'b0;
      act_src     <= '0;
    end else begin
      act_pulse   <= act_fire;
      inact_pulse <= inact_fire;
      if (act_fire) act_src <= hits_map;
    end
  end
endmodule

// File: rtl/aid_chk.sv
module aid_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       smp_valid,
  input logic [7:0] det_ctl,
  input logic       link_en,
  input logic       autosleep_en,
  input logic       act_pulse,
  input logic       inact_pulse,
  input logic [2:0] act_src,
  input logic       sleep_req
);
  // R1
  pulse_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_pulse || inact_pulse) |-> $past(smp_valid));

  // R5
  act_needs_axis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_pulse |-> ($past(det_ctl[6:4]) != 3'b000));

  // R3
  src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_src) |-> act_pulse);

  // R11
  sleep_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_req) |-> (inact_pulse && $past(link_en) && $past(autosleep_en)));

  // R11
  sleep_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_req) |-> (act_pulse || !$past(link_en) || !$past(autosleep_en)));

  // R9
  link_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(link_en) && ($past(det_ctl[6:4]) != 3'b000) && ($past(det_ctl[2:0]) != 3'b000))
      |-> !(act_pulse && inact_pulse));
endmodule

bind act_inact_det aid_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .smp_valid    (smp_valid),
  .det_ctl      (det_ctl),
  .link_en      (link_en),
  .autosleep_en (autosleep_en),
  .act_pulse    (act_pulse),
  .inact_pulse  (inact_pulse),
  .act_src      (act_src),
  .sleep_req    (sleep_req)
);

// File: tb/sim_act_inact_det.sv
module sim_act_inact_det;
  localparam int SW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_valid = 1'b0;
  logic          smp_ready;
  logic [3*SW-1:0] smp_data = '0;
  logic          sec_tick = 1'b0;
  logic [7:0]    act_thr = 8'd20;
  logic [7:0]    inact_thr = 8'd10;
  logic [7:0]    inact_time = 8'd0;
  logic [7:0]    det_ctl = 8'h00;
  logic          link_en = 1'b0;
  logic          autosleep_en = 1'b0;
  logic          act_pulse, inact_pulse, sleep_req;
  logic [2:0]    act_src;

  int n_chk = 0;
  int n_err = 0;
  int o_act, o_inact;
  int rv[3];
  bit rok = 0;

  always #2 clk = ~clk;

  act_inact_det #(.SW(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .sec_tick(sec_tick), .act_thr(act_thr),
    .inact_thr(inact_thr), .inact_time(inact_time), .det_ctl(det_ctl),
    .link_en(link_en), .autosleep_en(autosleep_en), .act_pulse(act_pulse),
    .inact_pulse(inact_pulse), .act_src(act_src), .sleep_req(sleep_req)
  );

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic send(input int x, input int y, input int z);
    @(negedge clk);
    smp_data  = {10'(z), 10'(y), 10'(x)};
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    o_act   = int'(act_pulse);
    o_inact = int'(inact_pulse);
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  // ac activity model: reference capture, compare, recapture after a hit
  task automatic ac_step(input int x, input int y, input int z);
    int s[3];
    bit e;
    s = '{x, y, z};
    e = 0;
    if (!rok) begin
      rv = s;
      rok = 1;
    end else begin
      for (int i = 0; i < 3; i++) if (iabs(s[i] - rv[i]) > 20) e = 1;
      if (e) rok = 0;
    end
    send(x, y, z);
    chk("R4 ac activity", o_act, int'(e));
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and ready
    chk("R1 ready", int'(smp_ready), 1);
    chk("R1 act reset", int'(act_pulse), 0);
    chk("R1 inact reset", int'(inact_pulse), 0);
    chk("R3 src reset", int'(act_src), 0);
    chk("R11 sleep reset", int'(sleep_req), 0);

    // R2 dc activity sweep across the threshold on each axis
    det_ctl = 8'h70;
    for (int ax = 0; ax < 3; ax++) begin
      for (int v = -30; v <= 30; v++) begin
        send(ax == 0 ? v : 0, ax == 1 ? v : 0, ax == 2 ? v : 0);
        chk("R2 dc activity", o_act, int'(iabs(v) > 20));
        if (iabs(v) > 20) chk("R3 source axis", int'(act_src), 1 << (2 - ax));
      end
    end
    send(30, -30, 5);
    chk("R3 multi-axis source", int'(act_src), 3'b110);
    send(0, 0, 0);
    chk("R3 source held", int'(act_src), 3'b110);

    // R5 enable mask sweep, mask 0 turns activity off
    for (int m = 0; m < 8; m++) begin
      det_ctl = 8'(m << 4);
      for (int ax = 0; ax < 3; ax++) begin
        send(ax == 0 ? 25 : 0, ax == 1 ? -25 : 0, ax == 2 ? 25 : 0);
        chk("R5 activity enable", o_act, (m >> (2 - ax)) & 1);
      end
    end

    // R4 ac activity with a tracked reference
    det_ctl = 8'hF0;
    rok = 0;
    for (int d = -30; d <= 30; d += 3) begin
      ac_step(100, -50, 7);
      ac_step(100 + d, -50, 7);
    end
    for (int d = -24; d <= 24; d += 4) begin
      ac_step(-3, 40 + d, 7);
    end

    // R6 dc inactivity, threshold 10, time 0
    det_ctl = 8'h07;
    inact_thr = 8'd10;
    inact_time = 8'd0;
    send(5, -5, 9);
    chk("R6 quiet fires", o_inact, 1);
    send(5, 5, 5);
    chk("R6 one pulse per quiet run", o_inact, 0);
    send(10, 0, 0);
    chk("R6 equal is not quiet", o_inact, 0);
    send(0, 0, -9);
    chk("R6 quiet after restart", o_inact, 1);
    det_ctl = 8'h03;
    send(0, 50, 0);
    chk("R5 enabled axis loud", o_inact, 0);
    send(300, 0, 0);
    chk("R5 disabled axis ignored", o_inact, 1);

    // R7 timer sweep: loud, quiet, k ticks, quiet
    det_ctl = 8'h07;
    for (int t = 0; t < 5; t++) begin
      inact_time = 8'(t);
      for (int k = 0; k < 6; k++) begin
        send(50, 0, 0);
        send(0, 0, 0);
        chk("R7 first quiet sample", o_inact, int'(t == 0));
        repeat (k) tick();
        send(0, 0, 0);
        chk("R7 after ticks", o_inact, int'((t != 0) && (k >= t)));
      end
    end
    inact_time = 8'd3;
    send(50, 0, 0);
    tick(); tick(); tick();
    send(0, 0, 0);
    chk("R7 ticks before run ignored", o_inact, 0);
    tick(); tick();
    send(0, 50, 0);
    send(0, 0, 0);
    tick(); tick();
    send(0, 0, 0);
    chk("R7 restart clears count", o_inact, 0);
    tick();
    send(0, 0, 0);
    chk("R7 count reached", o_inact, 1);

    // R8 ac inactivity with reference refresh
    inact_time = 8'd0;
    det_ctl = 8'h0F;
    send(200, 100, -100);
    chk("R8 reference capture", o_inact, 0);
    send(205, 95, -91);
    chk("R8 near reference", o_inact, 1);
    send(220, 100, -100);
    chk("R8 loud refreshes", o_inact, 0);
    send(225, 100, -100);
    chk("R8 new reference used", o_inact, 1);

    // R9 linked operation
    act_thr = 8'd20;
    det_ctl = 8'h77;
    link_en = 1'b1;
    send(50, 0, 0);
    chk("R9 activity held off", o_act, 0);
    send(0, 0, 0);
    chk("R9 inactivity first", o_inact, 1);
    send(0, 0, 0);
    chk("R9 inactivity held off", o_inact, 0);
    send(50, 0, 0);
    chk("R9 activity after inactivity", o_act, 1);
    send(60, 0, 0);
    chk("R9 activity held off again", o_act, 0);
    send(0, 0, 0);
    chk("R9 inactivity resumes", o_inact, 1);

    // R10 concurrent operation
    link_en = 1'b0;
    send(50, 0, 0);
    chk("R10 activity concurrent", o_act, 1);
    send(0, 0, 0);
    chk("R10 inactivity concurrent", o_inact, 1);
    send(0, 60, 0);
    chk("R10 activity again", o_act, 1);

    // R11 auto-sleep
    link_en = 1'b1;
    autosleep_en = 1'b1;
    send(50, 0, 0);
    chk("R11 no sleep before inactivity", int'(sleep_req), 0);
    send(0, 0, 0);
    chk("R11 sleep on inactivity", int'(sleep_req), 1);
    send(0, 0, 0);
    chk("R11 sleep held", int'(sleep_req), 1);
    send(50, 0, 0);
    chk("R11 wake on activity", int'(sleep_req), 0);
    link_en = 1'b0;
    send(50, 0, 0);
    send(0, 0, 0);
    chk("R11 inactivity without link", o_inact, 1);
    chk("R11 no sleep without link", int'(sleep_req), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule